// File: doc/BRIEF.md
# Next-Event Delay Checker

This block watches two single-bit conditions in a synchronous design: a trigger (`start_evt`) and a condition under test (`test_expr`). Each accepted trigger opens a timing window of `num_cks` clock cycles. The condition under test is required to be high on exactly the clock edge that lies `num_cks` edges after the edge that sampled the trigger. The condition is ignored on every other edge. A missing condition produces a one-cycle pulse on `fail_miss`.

The window is tracked by a single down-counter. Only one window can be open at a time. A new trigger is accepted only when the running window is in its final cycle or is already closed. A trigger that comes earlier is reported on `fail_overlap`. That rejected trigger leaves the running window untouched.

Both fail outputs are registered. They go high in the cycle that follows the offending edge. The block is meant to be instantiated next to the logic it monitors, and its fail pulses are gathered by the surrounding error logic.

Top module: `ndc_next_event_checker`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) closes the window: after that edge `win_active`, `fail_miss` and `fail_overlap` are all 0, and no check from a window opened before the reset is made afterwards.
- R2: A trigger sampled at edge s while no window is open loads `num_cks` (which must be at least 1). `win_active` is then 1 after edges s through s+`num_cks`-1, and returns to 0 after edge s+`num_cks` unless a new trigger is accepted at that edge.
- R3: If `test_expr` is 0 at edge s+`num_cks` of an open window, `fail_miss` is 1 for exactly the one cycle after that edge.
- R4: If `test_expr` is 1 at the closing edge, `fail_miss` stays 0. The value of `test_expr` at any other edge has no effect on either fail output.
- R5: A trigger sampled while more than one cycle of the window remains makes `fail_overlap` 1 for the following cycle. The rejected trigger does not restart the window, and the original closing edge is still the one that is checked.
- R6: A trigger sampled on the closing edge of a window is legal (`fail_overlap` stays 0). That edge both checks the old window and opens a new one of `num_cks` cycles.
- R7: While no window is open and no trigger arrives, `win_active`, `fail_miss` and `fail_overlap` stay 0 whatever `test_expr` does.
- R8: With `num_cks` = 1, a trigger on every edge is legal, and `test_expr` is checked on each edge that follows a trigger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_evt | input | 1 | Trigger that opens a delay window |
| test_expr | input | 1 | Condition required at the closing edge |
| num_cks | input | CNT_W | Window length in cycles, at least 1 when a trigger is sampled |
| win_active | output | 1 | A window is open |
| fail_miss | output | 1 | One-cycle pulse: condition absent at the closing edge |
| fail_overlap | output | 1 | One-cycle pulse: trigger arrived too early |

## Verification
The properties assume that `num_cks` is nonzero whenever `start_evt` is sampled high, and that all inputs change only away from the rising edge. One property states the first assumption explicitly. The stimulus drives every input at the falling edge and uses window lengths of 1 to 200, which stay inside the 8-bit default width. A model in the stimulus side tracks the due edge of the open window as an absolute edge number. It derives the expected pulses from that number, and it exercises both mid-window resets and triggers that are rejected.

// File: rtl/ndc_pkg.sv
package ndc_pkg;

  typedef enum logic [1:0] {
    WIN_IDLE    = 2'd0,
    WIN_RUN     = 2'd1,
    WIN_CLOSING = 2'd2
  } win_phase_e;

  // Phase of the window for a given remaining count.
  function automatic win_phase_e phase_of(input int unsigned remaining);
    if (remaining == 0)      return WIN_IDLE;
    else if (remaining == 1) return WIN_CLOSING;
    else                     return WIN_RUN;
  endfunction

  // A new trigger is accepted when at most the closing cycle remains.
  function automatic bit start_is_legal(input int unsigned remaining);
    return remaining <= 1;
  endfunction

  // Count after the next edge.
  function automatic int unsigned count_after(input int unsigned remaining,
                                              input bit          load,
                                              input int unsigned length);
    if (load)                return length;
    else if (remaining == 0) return 0;
    else                     return remaining - 1;
  endfunction

endpackage

// File: rtl/ndc_window_cnt.sv
module ndc_window_cnt #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] length,
  output logic [CNT_W-1:0] cnt_q
);
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = CNT_W'(ndc_pkg::count_after(32'(cnt_q), load, 32'(length)));
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ndc_start_gate.sv
module ndc_start_gate #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             start_evt,
  input  logic             test_expr,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             load,
  output logic             overlap_evt,
  output logic             expire_evt,
  output logic             miss_evt,
  output logic             open
);
  ndc_pkg::win_phase_e phase;
  logic                legal;

  always_comb begin
    phase       = ndc_pkg::phase_of(32'(cnt_q));
    legal       = ndc_pkg::start_is_legal(32'(cnt_q));
    load        = start_evt & legal;
    overlap_evt = start_evt & ~legal;
    expire_evt  = (phase == ndc_pkg::WIN_CLOSING);
    miss_evt    = expire_evt & ~test_expr;
    open        = (phase != ndc_pkg::WIN_IDLE);
  end
endmodule

// File: rtl/ndc_fail_reg.sv
module ndc_fail_reg (
  input  logic clk,
  input  logic rst,
  input  logic miss_evt,
  input  logic overlap_evt,
  output logic fail_miss,
  output logic fail_overlap
);
  always_ff @(posedge clk) begin
    if (rst) begin
      fail_miss    <= 1'b0;
      fail_overlap <= 1'b0;
    end else begin
      fail_miss    <= miss_evt;
      fail_overlap <= overlap_evt;
    end
  end
endmodule

// File: rtl/ndc_next_event_checker.sv
module ndc_next_event_checker #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_evt,
  input  logic             test_expr,
  input  logic [CNT_W-1:0] num_cks,
  output logic             win_active,
  output logic             fail_miss,
  output logic             fail_overlap
);
  // Named internal events, visible to the bound checker.
  logic [CNT_W-1:0] cnt_q;
  logic             load;
  logic             overlap_evt;
  logic             expire_evt;
  logic             miss_evt;

  ndc_window_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .length (num_cks),
    .cnt_q  (cnt_q)
  );

  ndc_start_gate #(.CNT_W(CNT_W)) u_gate (
    .start_evt   (start_evt),
    .test_expr   (test_expr),
    .cnt_q       (cnt_q),
    .load        (load),
    .overlap_evt (overlap_evt),
    .expire_evt  (expire_evt),
    .miss_evt    (miss_evt),
    .open        (win_active)
  );

  ndc_fail_reg u_fail (
    .clk          (clk),
    .rst          (rst),
    .miss_evt     (miss_evt),
    .overlap_evt  (overlap_evt),
    .fail_miss    (fail_miss),
    .fail_overlap (fail_overlap)
  );
endmodule

// File: rtl/ndc_next_event_checker_sva.sv
module ndc_next_event_checker_sva #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             start_evt,
  input logic             test_expr,
  input logic [CNT_W-1:0] num_cks,
  input logic [CNT_W-1:0] cnt_q,
  input logic             win_active,
  input logic             fail_miss,
  input logic             fail_overlap
);
  // Input assumption for R2: the length is nonzero when a trigger is sampled.
  p_len_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    start_evt |-> (num_cks != '0));

  p_load_r2: assert property (@(posedge clk) disable iff (rst)
    (start_evt && cnt_q <= CNT_W'(1)) |=> (cnt_q == $past(num_cks)) && win_active);

  p_miss_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_W'(1) && !test_expr) |=> fail_miss);

  p_no_miss_r4: assert property (@(posedge clk) disable iff (rst)
    !(cnt_q == CNT_W'(1) && !test_expr) |=> !fail_miss);

  p_overlap_r5: assert property (@(posedge clk) disable iff (rst)
    (start_evt && cnt_q > CNT_W'(1)) |=> fail_overlap && (cnt_q == $past(cnt_q) - CNT_W'(1)));

  p_closing_start_r6: assert property (@(posedge clk) disable iff (rst)
    (start_evt && cnt_q == CNT_W'(1)) |=> !fail_overlap);

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !start_evt) |=> (cnt_q == '0) && !win_active && !fail_miss && !fail_overlap);

  p_countdown_r2: assert property (@(posedge clk) disable iff (rst)
    (!start_evt && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
endmodule

bind ndc_next_event_checker ndc_next_event_checker_sva #(.CNT_W(CNT_W)) u_sva (
  .clk          (clk),
  .rst          (rst),
  .start_evt    (start_evt),
  .test_expr    (test_expr),
  .num_cks      (num_cks),
  .cnt_q        (cnt_q),
  .win_active   (win_active),
  .fail_miss    (fail_miss),
  .fail_overlap (fail_overlap)
);

// File: tb/test_ndc_next_event_checker.sv
`timescale 1ns/1ps
module test_ndc_next_event_checker;
  localparam int unsigned CNT_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_evt = 1'b0;
  logic             test_expr = 1'b0;
  logic [CNT_W-1:0] num_cks = CNT_W'(1);
  logic             win_active;
  logic             fail_miss;
  logic             fail_overlap;

  always #2 clk = ~clk;

  ndc_next_event_checker #(.CNT_W(CNT_W)) i_ndc_next_event_checker (
    .clk          (clk),
    .rst          (rst),
    .start_evt    (start_evt),
    .test_expr    (test_expr),
    .num_cks      (num_cks),
    .win_active   (win_active),
    .fail_miss    (fail_miss),
    .fail_overlap (fail_overlap)
  );

  typedef struct {
    bit    miss;
    bit    ovl;
    bit    act;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int   checks   = 0;
  int   failures = 0;
  int   edge_no  = 0;   // index of the next rising edge
  int   due      = -1;  // edge at which the open window is checked, -1 = none
  bit   done     = 0;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // Driver: sets inputs at the falling edge, predicts outputs after the next rising edge.
  task automatic step(input bit r, input bit s, input bit t, input int n, input string tag);
    int  rem;
    exp_t e;
    @(negedge clk);
    rst = r; start_evt = s; test_expr = t; num_cks = CNT_W'(n);
    rem   = (due >= edge_no) ? (due - edge_no + 1) : 0;
    e.miss = !r && rem == 1 && !t;
    e.ovl  = !r && s && rem > 1;
    if (r)                  due = -1;
    else if (s && rem <= 1) due = edge_no + n;
    e.act = (due >= edge_no + 1);
    e.tag = tag;
    edge_no++;
    @(posedge clk);
    sb_q.push_back(e);
  endtask

  // One window: trigger, then the opposite of the required value, then the required value at the closing edge.
  task automatic window(input int n, input bit t_due, input string tag);
    step(0, 1, ~t_due, n, tag);
    for (int i = 1; i < n; i++) step(0, 0, ~t_due, n, tag);
    step(0, 0, t_due, n, tag);
  endtask

  // Monitor: pops one prediction per cycle and compares.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (fail_miss !== e.miss || fail_overlap !== e.ovl || win_active !== e.act) begin
        failures++;
        $display("FAIL %s: miss/ovl/act actual=%b%b%b expected=%b%b%b",
                 e.tag, fail_miss, fail_overlap, win_active, e.miss, e.ovl, e.act);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: state held by reset
    checks++;
    if (win_active !== 1'b0 || fail_miss !== 1'b0 || fail_overlap !== 1'b0) begin
      failures++;
      $display("FAIL R1: actual=%b%b%b expected=000", fail_miss, fail_overlap, win_active);
    end
    rst = 1'b0;
    edge_no = 0;

    // R7: idle with a toggling condition
    for (int i = 0; i < 6; i++) step(0, 0, i[0], 3, "R7");

    // R2 and R4: condition present at the closing edge, absent elsewhere
    window(4, 1, "R2_R4");
    window(7, 1, "R4");
    // R3: condition absent at the closing edge
    window(3, 0, "R3");
    window(1, 0, "R3");
    step(0, 0, 0, 1, "R7");

    // R5: early trigger rejected, original closing edge still checked
    step(0, 1, 0, 5, "R5");
    step(0, 0, 0, 5, "R5");
    step(0, 1, 0, 9, "R5");
    step(0, 0, 0, 5, "R5");
    step(0, 0, 0, 5, "R5");
    step(0, 0, 1, 5, "R5");
    step(0, 0, 0, 5, "R5");
    step(0, 1, 1, 4, "R5");
    step(0, 1, 1, 4, "R5");
    step(0, 0, 1, 4, "R5");
    step(0, 0, 1, 4, "R5");
    step(0, 0, 0, 4, "R5");
    step(0, 0, 0, 4, "R5");

    // R6: trigger on the closing edge opens a new window
    step(0, 1, 0, 3, "R6");
    step(0, 0, 0, 3, "R6");
    step(0, 0, 0, 3, "R6");
    step(0, 1, 1, 2, "R6");
    step(0, 0, 1, 2, "R6");
    step(0, 0, 0, 2, "R6");
    step(0, 1, 0, 2, "R6");
    step(0, 0, 1, 2, "R6");
    step(0, 0, 1, 2, "R6");

    // R8: length one, trigger every edge
    for (int i = 0; i < 8; i++) step(0, 1, (i % 3) != 0, 1, "R8");
    step(0, 0, 0, 1, "R8");
    step(0, 0, 0, 1, "R8");

    // R1: reset in the middle of a window drops the pending check
    step(0, 1, 0, 6, "R1");
    step(0, 0, 0, 6, "R1");
    step(1, 0, 0, 6, "R1");
    for (int i = 0; i < 8; i++) step(0, 0, 0, 6, "R1");

    // R2: long window
    window(200, 1, "R2");
    window(200, 0, "R3");
    step(0, 0, 0, 1, "R7");

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule